// File: doc/BRIEF.md
# Vertical Timebase Divider with Adaptive Sync Windows

This block derives the vertical timebase of a raster display from a clock enable that pulses twice per horizontal line, so one count equals one half-line. A free-running half-line counter is restarted by the separated vertical sync pulse, but only when that pulse falls inside an acceptance window. The position of the accepted pulse also decides whether the incoming field rate is 60 Hz or 50 Hz.

Two acceptance windows exist. A wide search window is used while a new signal is being acquired. A narrow window around the expected field length rejects noise once the signal is trusted. The choice between them comes from a saturating 4-bit confidence counter that moves up on each accepted pulse and down on each rejected or missing one, with hysteresis between entering and leaving narrow mode. The block also drives a gate pulse that holds off the horizontal phase detector around vertical sync.

Inputs are sampled only on clock edges where the half-line enable is high. The sync input is edge-detected on those samples, so a long pulse is evaluated once.

Top module: `vsync_divider`

## Requirements
- R1: After reset, all outputs are low (50 Hz, wide window, gate off). The count and the confidence counter start at 0.
- R2: Inputs are sampled and state advances only on clock edges with `hl_en_i` high. Sync or strobe changes between enabled edges have no effect.
- R3: In wide mode, a sync rising edge sampled at count C with 488 <= C <= 628 restarts the count to 0 and raises `vreset_o` for one clock. An edge at C < 488 does not restart the count.
- R4: On a wide-mode restart by sync, `rate60_o` becomes 1 if C < 576 and 0 otherwise. `rate60_o` changes at no other time.
- R5: In wide mode with no accepted edge, the divider restarts itself when it samples count 628, which is 629 enabled edges per field.
- R6: The confidence counter adds 1 (saturating at 15) for each restart by sync. It subtracts 1 (floored at 0) for each rejected edge and each self-restart. Narrow mode (`narrow_o`=1) is entered when the counter reaches 15.
- R7: In narrow mode the window is counts 522..528 when `rate60_o`=1 and 622..628 when `rate60_o`=0. Edges outside the window do not restart the count.
- R8: In narrow mode, with no sync edge in the window, the divider restarts at the window's last count. Narrow mode is left only when the confidence counter drops below 10.
- R9: The gate `atf_o` ends when the count reaches 10 (50 Hz) or 12 (60 Hz).
- R10: In wide mode, `atf_o` starts at a divider restart. In narrow mode it starts at an `eq_start_i` sample, and restarts do not start it. In wide mode `eq_start_i` is ignored.
- R11: A sync level held high across several enabled edges counts as one edge, at its first high sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hl_en_i | input | 1 | Half-line clock enable |
| vsync_i | input | 1 | Separated vertical sync level |
| eq_start_i | input | 1 | Strobe at the first equalizing pulse |
| vreset_o | output | 1 | One-clock vertical restart pulse |
| rate60_o | output | 1 | 1 = 60 Hz field, 0 = 50 Hz field |
| narrow_o | output | 1 | 1 = narrow window active |
| atf_o | output | 1 | Phase-detector inhibit gate |

## Verification
On every cycle, the assertions check these invariants: the count stays within the longest field, the count is 0 during a restart pulse, the counter never wraps, narrow mode implies a confidence of at least 10 and is entered only at full confidence, the count stays within the narrow window, and the gate rises and falls only at the counts it should. Only the bench scenarios can show the following: exact field lengths for accepted, ignored and missing pulses; the 575/576 rate boundary and the 487/488 acceptance boundary; the hysteresis margin of five misses; rejection of strobes in wide mode; and single evaluation of a held sync level.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
  typedef struct packed {
    logic restart;
    logic hit;
    logic miss;
    logic rate_upd;
    logic set60;
  } vdiv_dec_t;
endpackage

// File: rtl/vdiv_window.sv
module vdiv_window
  import vdiv_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int LARGE_LO   = 488,
  parameter int RATE_SPLIT = 576,
  parameter int LARGE_HI   = 628,
  parameter int N60_LO     = 522,
  parameter int N60_HI     = 528,
  parameter int N50_LO     = 622,
  parameter int N50_HI     = 628
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             edge_i,
  input  logic             narrow_i,
  input  logic             rate60_i,
  output vdiv_dec_t        dec_o
);
  localparam logic [CNT_W-1:0] LLO = CNT_W'(LARGE_LO);
  localparam logic [CNT_W-1:0] LHI = CNT_W'(LARGE_HI);
  localparam logic [CNT_W-1:0] LSP = CNT_W'(RATE_SPLIT);
  localparam logic [CNT_W-1:0] A_LO = CNT_W'(N60_LO);
  localparam logic [CNT_W-1:0] A_HI = CNT_W'(N60_HI);
  localparam logic [CNT_W-1:0] B_LO = CNT_W'(N50_LO);
  localparam logic [CNT_W-1:0] B_HI = CNT_W'(N50_HI);

  logic [CNT_W-1:0] nlo, nhi;
  logic in_large, in_narrow;

  assign nlo       = rate60_i ? A_LO : B_LO;
  assign nhi       = rate60_i ? A_HI : B_HI;
  assign in_large  = (cnt_i >= LLO) && (cnt_i <= LHI);
  assign in_narrow = (cnt_i >= nlo) && (cnt_i <= nhi);

  always_comb begin
    dec_o = '0;
    if (!narrow_i) begin
      if (edge_i && in_large) begin
        dec_o.restart  = 1'b1;
        dec_o.hit      = 1'b1;
        dec_o.rate_upd = 1'b1;
        dec_o.set60    = cnt_i < LSP;
      end else if (edge_i) begin
        dec_o.miss = 1'b1;
      end else if (cnt_i == LHI) begin
        dec_o.restart = 1'b1;
        dec_o.miss    = 1'b1;
      end
    end else begin
      if (edge_i && in_narrow) begin
        dec_o.restart = 1'b1;
        dec_o.hit     = 1'b1;
      end else begin
        if (edge_i) dec_o.miss = 1'b1;
        if (cnt_i == nhi) begin
          dec_o.restart = 1'b1;
          dec_o.miss    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vdiv_conf.sv
module vdiv_conf #(
  parameter int CONF_W = 4,
  parameter int ENTER  = 15,
  parameter int EXIT   = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic miss_i,
  output logic narrow_o
);
  localparam logic [CONF_W-1:0] CMAX = {CONF_W{1'b1}};
  localparam logic [CONF_W-1:0] CENT = CONF_W'(ENTER);
  localparam logic [CONF_W-1:0] CEXT = CONF_W'(EXIT);

  logic [CONF_W-1:0] conf_q, conf_d;
  logic narrow_d;

  always_comb begin
    conf_d = conf_q;
    if (hit_i && conf_q != CMAX)           conf_d = conf_q + 1'b1;
    else if (miss_i && conf_q != '0)       conf_d = conf_q - 1'b1;
    narrow_d = narrow_o;
    if (conf_d >= CENT)                    narrow_d = 1'b1;
    else if (conf_d < CEXT)                narrow_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conf_q   <= '0;
      narrow_o <= 1'b0;
    end else if (tick_i) begin
      conf_q   <= conf_d;
      narrow_o <= narrow_d;
    end
  end

  // R6
  conf_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf_q == CMAX) |=> (conf_q >= CMAX - 1'b1));
  // R8
  narrow_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_o |-> (conf_q >= CEXT));
  // R6
  narrow_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(narrow_o) |-> (conf_q >= CENT));
endmodule

// File: rtl/vdiv_atf.sv
module vdiv_atf #(
  parameter int CNT_W     = 10,
  parameter int ATF_END50 = 10,
  parameter int ATF_END60 = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             narrow_i,
  input  logic             eq_i,
  input  logic             rate60_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  output logic             atf_o
);
  localparam logic [CNT_W-1:0] E50 = CNT_W'(ATF_END50);
  localparam logic [CNT_W-1:0] E60 = CNT_W'(ATF_END60);

  logic [CNT_W-1:0] end_cnt;
  assign end_cnt = rate60_i ? E60 : E50;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          atf_o <= 1'b0;
    else if (tick_i) begin
      if (!narrow_i && restart_i)         atf_o <= 1'b1;
      else if (narrow_i && eq_i)          atf_o <= 1'b1;
      else if (cnt_next_i == end_cnt)     atf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vsync_divider.sv
module vsync_divider
  import vdiv_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int LARGE_LO   = 488,
  parameter int RATE_SPLIT = 576,
  parameter int LARGE_HI   = 628,
  parameter int N60_LO     = 522,
  parameter int N60_HI     = 528,
  parameter int N50_LO     = 622,
  parameter int N50_HI     = 628,
  parameter int CONF_W     = 4,
  parameter int ENTER      = 15,
  parameter int EXIT       = 10,
  parameter int ATF_END50  = 10,
  parameter int ATF_END60  = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hl_en_i,
  input  logic vsync_i,
  input  logic eq_start_i,
  output logic vreset_o,
  output logic rate60_o,
  output logic narrow_o,
  output logic atf_o
);
  localparam logic [CNT_W-1:0] LHI  = CNT_W'(LARGE_HI);
  localparam logic [CNT_W-1:0] A_HI = CNT_W'(N60_HI);
  localparam logic [CNT_W-1:0] B_HI = CNT_W'(N50_HI);
  localparam logic [CNT_W-1:0] E50  = CNT_W'(ATF_END50);
  localparam logic [CNT_W-1:0] E60  = CNT_W'(ATF_END60);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic vs_prev_q, sync_edge, restart;
  vdiv_dec_t dec;

  assign sync_edge = hl_en_i & vsync_i & ~vs_prev_q;
  assign restart   = hl_en_i & dec.restart;
  assign cnt_d     = dec.restart ? '0 : cnt_q + 1'b1;

  vdiv_window #(
    .CNT_W(CNT_W), .LARGE_LO(LARGE_LO), .RATE_SPLIT(RATE_SPLIT), .LARGE_HI(LARGE_HI),
    .N60_LO(N60_LO), .N60_HI(N60_HI), .N50_LO(N50_LO), .N50_HI(N50_HI)
  ) u_win (
    .cnt_i(cnt_q), .edge_i(sync_edge), .narrow_i(narrow_o), .rate60_i(rate60_o), .dec_o(dec)
  );

  vdiv_conf #(.CONF_W(CONF_W), .ENTER(ENTER), .EXIT(EXIT)) u_conf (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(hl_en_i),
    .hit_i(dec.hit), .miss_i(dec.miss), .narrow_o(narrow_o)
  );

  vdiv_atf #(.CNT_W(CNT_W), .ATF_END50(ATF_END50), .ATF_END60(ATF_END60)) u_atf (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(hl_en_i), .restart_i(dec.restart),
    .narrow_i(narrow_o), .eq_i(eq_start_i), .rate60_i(rate60_o),
    .cnt_next_i(cnt_d), .atf_o(atf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      vs_prev_q <= 1'b0;
      rate60_o  <= 1'b0;
      vreset_o  <= 1'b0;
    end else begin
      vreset_o <= restart;
      if (hl_en_i) begin
        cnt_q     <= cnt_d;
        vs_prev_q <= vsync_i;
        if (dec.rate_upd) rate60_o <= dec.set60;
      end
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LHI);
  // R3
  reset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vreset_o |-> (cnt_q == '0));
  // R7
  narrow60_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_o && rate60_o) |-> (cnt_q <= A_HI));
  // R7
  narrow50_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_o && !rate60_o) |-> (cnt_q <= B_HI));
  // R10
  atf_wide_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(atf_o) && !$past(narrow_o)) |-> (cnt_q == '0));
  // R9
  atf_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(atf_o) |-> (cnt_q == (rate60_o ? E60 : E50)));
  // R4
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate60_o != $past(rate60_o)) |-> vreset_o);
endmodule

// File: tb/vsync_divider_tb.sv
module vsync_divider_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni, hl_en, vs, eq;
  logic vreset_o, rate60_o, narrow_o, atf_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1";

  int m_cnt, m_conf;
  bit m_narrow, m_rate, m_atf, m_prev, m_vres;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_divider u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hl_en_i(hl_en), .vsync_i(vs), .eq_start_i(eq),
    .vreset_o(vreset_o), .rate60_o(rate60_o), .narrow_o(narrow_o), .atf_o(atf_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_tick(input bit v, input bit e);
    bit edg, rst, hit, miss;
    int c, lo, hi, cn, endc, nc;
    edg = v && !m_prev;
    m_prev = v;
    c = m_cnt; rst = 0; hit = 0; miss = 0;
    if (!m_narrow) begin
      if (edg && c >= 488 && c <= 628) begin
        rst = 1; hit = 1; m_rate_next(c);
      end else if (edg) miss = 1;
      else if (c == 628) begin rst = 1; miss = 1; end
    end else begin
      lo = m_rate ? 522 : 622;
      hi = m_rate ? 528 : 628;
      if (edg && c >= lo && c <= hi) begin rst = 1; hit = 1; end
      else begin
        if (edg) miss = 1;
        if (c == hi) begin rst = 1; miss = 1; end
      end
    end
    cn = rst ? 0 : c + 1;
    endc = m_rate ? 12 : 10;
    if (!m_narrow && rst) m_atf = 1;
    else if (m_narrow && e) m_atf = 1;
    else if (cn == endc) m_atf = 0;
    nc = m_conf;
    if (hit && nc < 15) nc++;
    else if (miss && nc > 0) nc--;
    m_conf = nc;
    if (nc == 15) m_narrow = 1;
    else if (nc < 10) m_narrow = 0;
    if (rst && !m_narrow_was_hold) ;
    m_cnt = cn;
    m_vres = rst;
    if (pend_rate_valid) begin m_rate = pend_rate; pend_rate_valid = 0; end
  endtask

  bit pend_rate, pend_rate_valid = 0, m_narrow_was_hold = 0;
  task automatic m_rate_next(input int c);
    pend_rate = (c < 576);
    pend_rate_valid = 1;
  endtask

  task automatic compare();
    chk(phase, "vreset_o", vreset_o, m_vres);
    chk(phase, "rate60_o", rate60_o, m_rate);
    chk(phase, "narrow_o", narrow_o, m_narrow);
    chk(phase, "atf_o", atf_o, m_atf);
  endtask

  task automatic cyc(input bit en, input bit v, input bit e);
    hl_en = en; vs = v; eq = e;
    if (en) model_tick(v, e);
    else m_vres = 0;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  // one enabled edge, sometimes preceded by an idle cycle with junk inputs (R2)
  task automatic tick(input bit v, input bit e);
    if ($urandom % 4 == 0) cyc(0, 1'($urandom), 1'($urandom));
    cyc(1, v, e);
  endtask

  task automatic run_field(input int trig, input int w, input int noise, input int eq_pos,
                           output int n);
    bit v;
    n = 0;
    for (int i = 0; i < 700; i++) begin
      v = (trig >= 0 && m_cnt >= trig && m_cnt < trig + w) ||
          (noise >= 0 && m_cnt >= noise && m_cnt < noise + 2);
      tick(v, m_cnt == eq_pos);
      n = i + 1;
      if (m_vres) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    rst_ni = 0; hl_en = 0; vs = 0; eq = 0;
    m_cnt = 0; m_conf = 0; m_narrow = 0; m_rate = 0; m_atf = 0; m_prev = 0; m_vres = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    phase = "R1";
    compare();
    chk("R1", "all outputs low", {vreset_o, rate60_o, narrow_o, atf_o}, 0);

    phase = "R5";
    run_field(-1, 0, -1, -1, n);
    chk("R5", "free-run field length", n, 629);

    phase = "R3";
    run_field(530, 6, 400, -1, n);
    chk("R3", "early edge ignored, restart at 530", n, 531);
    chk("R4", "rate after 530", rate60_o, 1);

    phase = "R6";
    for (int k = 0; k < 13; k++) run_field(524, 6, -1, -1, n);
    chk("R6", "still wide at confidence 14", narrow_o, 0);
    run_field(524, 6, -1, -1, n);
    chk("R6", "narrow at confidence 15", narrow_o, 1);

    phase = "R7";
    run_field(515, 3, -1, -1, n);
    chk("R7", "outside edge ignored, end-of-window restart", n, 529);
    chk("R8", "narrow kept at confidence 13", narrow_o, 1);

    phase = "R10";
    run_field(524, 6, -1, 518, n);
    chk("R10", "gate started by strobe", atf_o, 1);
    chk("R7", "hit at 524", n, 525);

    phase = "R8";
    for (int k = 0; k < 4; k++) begin
      run_field(-1, 0, -1, -1, n);
      chk("R8", "missing-sync restart at 528", n, 529);
    end
    chk("R8", "narrow held by hysteresis", narrow_o, 1);
    run_field(-1, 0, -1, -1, n);
    chk("R8", "wide after confidence 9", narrow_o, 0);

    phase = "R10";
    run_field(560, 4, -1, 100, n);
    chk("R10", "hit at 560 in wide", n, 561);

    phase = "R9";
    for (int k = 0; k < 11; k++) tick(0, 0);
    chk("R9", "gate high at count 11 (60 Hz)", atf_o, 1);
    tick(0, 0);
    chk("R9", "gate low at count 12 (60 Hz)", atf_o, 0);
    run_field(-1, 0, -1, -1, n);

    phase = "R11";
    run_field(480, 30, -1, -1, n);
    chk("R11", "held sync evaluated once", n, 629);

    phase = "R3";
    run_field(487, 1, -1, -1, n);
    chk("R3", "edge at 487 rejected", n, 629);
    run_field(488, 3, -1, -1, n);
    chk("R3", "edge at 488 accepted", n, 489);

    phase = "R4";
    run_field(575, 3, -1, -1, n);
    chk("R4", "575 gives 60 Hz", rate60_o, 1);
    run_field(576, 3, -1, -1, n);
    chk("R4", "576 gives 50 Hz", rate60_o, 0);

    phase = "R9";
    for (int k = 0; k < 9; k++) tick(0, 0);
    chk("R9", "gate high at count 9 (50 Hz)", atf_o, 1);
    tick(0, 0);
    chk("R9", "gate low at count 10 (50 Hz)", atf_o, 0);
    run_field(-1, 0, -1, -1, n);

    phase = "R7";
    for (int k = 0; k < 16; k++) run_field(625, 4, -1, 618, n);
    chk("R7", "narrow at 50 Hz", narrow_o, 1);
    chk("R4", "rate stays 50 Hz", rate60_o, 0);
    run_field(619, 2, -1, -1, n);
    chk("R7", "50 Hz window end restart", n, 629);

    phase = "R2";
    for (int k = 0; k < 30; k++) begin
      int t = ($urandom % 5 == 0) ? -1 : int'($urandom_range(470, 640));
      int nz = ($urandom % 3 == 0) ? int'($urandom_range(50, 460)) : -1;
      run_field(t, int'($urandom_range(1, 8)), nz, int'($urandom_range(500, 627)), n);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule